// File: doc/BRIEF.md
# Page Permission and Alignment Checker

This block sits between a 32-bit core and main memory and judges every memory request in one cycle. A request carries a 24-bit byte address, an access kind (data read, data write or instruction fetch) and an operand size of 8, 16 or 32 bits. The block does two things with it. It checks that the address is aligned to the operand size. It also looks up the read, write and execute bits of the 256-byte page that holds the address. The answer is a grant, or a fault with a cause code. That answer appears on a registered response port one cycle after the request.

Software fills the permission table through a write port. Each write sets the three permission bits of one page. The table is built from flops that reset to "nothing allowed". It covers the lowest `TBL_PAGES` pages of the address space. Every page above that range is permanently denied.

Top module: `mem_perm_chk`

## Requirements
- R1: A request sampled with `req_valid_i` high produces `rsp_valid_o` high on the following cycle, together with its grant and cause. In a cycle after no request, `rsp_valid_o`, `rsp_grant_o` and `rsp_cause_o` are all zero.
- R2: The page number is `req_addr_i[23:8]`. The permission entry of a page has bit 0 = read, bit 1 = write and bit 2 = execute. Kind code 0 (read) needs bit 0, kind 1 (write) needs bit 1, and kinds 2 and 3 (fetch) need bit 2.
- R3: After reset, every page denies every kind of access.
- R4: Size code 0 (8-bit) is never misaligned. Size code 1 (16-bit) is misaligned when `req_addr_i[0]` is 1. Size codes 2 and 3 (32-bit) are misaligned when `req_addr_i[1:0]` is not zero.
- R5: A misaligned request reports cause 1, whatever the permission of its page.
- R6: The cause codes are: 0 = none, 1 = misaligned, 2 = read denied, 3 = write denied, 4 = execute denied.
- R7: A table write applies to requests from the next cycle on. A request in the same cycle as the write still sees the old entry.
- R8: Pages numbered `TBL_PAGES` or higher deny every kind of access. Table writes to those pages have no effect.
- R9: `rsp_grant_o` is 1 exactly when a valid response has cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_addr_i | input | 24 | Byte address of the request |
| req_kind_i | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cfg_we_i | input | 1 | Write one table entry |
| cfg_page_i | input | 16 | Page number to write |
| cfg_perm_i | input | 3 | New entry: bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_grant_o | output | 1 | The access is allowed |
| rsp_cause_o | output | 3 | Fault cause, 0 when granted |

## Verification
A corrupted table entry shows up as a wrong grant or a wrong denial cause. It appears in the cycle right after the first request that touches that page, and no earlier. A stale entry appears in the same way, and so does an entry updated one cycle too early, which is exposed by writing and requesting the same page in the same cycle. A wrong alignment decision or a wrong priority shows as cause 1 when a page fault was expected, or the reverse, on the very next response. The bench keeps its own copy of the table and feeds it random page writes mixed with requests. Directed cases cover every size/offset pair and pages above the table range.

// File: rtl/mem_perm_pkg.sv
package mem_perm_pkg;
  localparam int unsigned PERM_W = 3;
  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_EX = 2;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_FETCH_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'd0,
    SIZE_HALF = 2'd1,
    SIZE_WORD = 2'd2,
    SIZE_WORD_ALT = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_MISALIGN = 3'd1,
    CAUSE_RD_DENY  = 3'd2,
    CAUSE_WR_DENY  = 3'd3,
    CAUSE_EX_DENY  = 3'd4
  } fault_cause_e;
endpackage

// File: rtl/mem_perm_table.sv
module mem_perm_table
  import mem_perm_pkg::*;
#(
  parameter int unsigned PAGE_W    = 16,
  parameter int unsigned TBL_PAGES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  output logic [PERM_W-1:0] rd_perm_o
);
  localparam int unsigned IDX_W = (TBL_PAGES > 1) ? $clog2(TBL_PAGES) : 1;
  localparam logic [PAGE_W:0] LIMIT = (PAGE_W+1)'(TBL_PAGES);

  logic [PERM_W-1:0] ent_q [TBL_PAGES];
  logic              wr_hit, rd_hit;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_hit = wr_en_i && ({1'b0, wr_page_i} < LIMIT);
  assign rd_hit = {1'b0, rd_page_i} < LIMIT;
  assign wr_idx = wr_page_i[IDX_W-1:0];
  assign rd_idx = rd_page_i[IDX_W-1:0];

  for (genvar g = 0; g < TBL_PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q[g] <= '0;
      else if (wr_hit && wr_idx == IDX_W'(g))    ent_q[g] <= wr_perm_i;
    end
  end

  // Out-of-range pages read back as fully denied
  assign rd_perm_o = rd_hit ? ent_q[rd_idx] : '0;
endmodule

// File: rtl/mem_perm_align.sv
module mem_perm_align
  import mem_perm_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  output logic       misaligned_o
);
  always_comb begin
    unique case (acc_size_e'(size_i))
      SIZE_BYTE: misaligned_o = 1'b0;
      SIZE_HALF: misaligned_o = addr_lo_i[0];
      default:   misaligned_o = |addr_lo_i;
    endcase
  end
endmodule

// File: rtl/mem_perm_chk.sv
module mem_perm_chk
  import mem_perm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_OFS_W = 8,
  parameter int unsigned TBL_PAGES  = 1024,
  localparam int unsigned PAGE_W    = ADDR_W - PAGE_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_size_i,
  input  logic              cfg_we_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [2:0]        cfg_perm_i,
  output logic              rsp_valid_o,
  output logic              rsp_grant_o,
  output logic [2:0]        rsp_cause_o
);
  logic [PERM_W-1:0] page_perm;
  logic              misaligned;
  logic              allowed;
  fault_cause_e      deny_cause, cause_d;

  mem_perm_table #(.PAGE_W(PAGE_W), .TBL_PAGES(TBL_PAGES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_page_i (cfg_page_i),
    .wr_perm_i (cfg_perm_i),
    .rd_page_i (req_addr_i[ADDR_W-1:PAGE_OFS_W]),
    .rd_perm_o (page_perm)
  );

  mem_perm_align u_align (
    .size_i       (req_size_i),
    .addr_lo_i    (req_addr_i[1:0]),
    .misaligned_o (misaligned)
  );

  always_comb begin
    unique case (acc_kind_e'(req_kind_i))
      KIND_READ:  begin allowed = page_perm[PERM_RD]; deny_cause = CAUSE_RD_DENY; end
      KIND_WRITE: begin allowed = page_perm[PERM_WR]; deny_cause = CAUSE_WR_DENY; end
      default:    begin allowed = page_perm[PERM_EX]; deny_cause = CAUSE_EX_DENY; end
    endcase
  end

  // Alignment outranks permission
  always_comb begin
    if (misaligned)    cause_d = CAUSE_MISALIGN;
    else if (!allowed) cause_d = deny_cause;
    else               cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_cause_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_grant_o <= req_valid_i && (cause_d == CAUSE_NONE);
      rsp_cause_o <= req_valid_i ? cause_d : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/mem_perm_chk_sva.sv
module mem_perm_chk_sva #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_grant_o,
  input logic [2:0]        rsp_cause_o
);
  p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_grant_o && rsp_cause_o == 3'd0));
  p_word_misalign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i[1] && req_addr_i[1:0] != 2'b00) |=> rsp_cause_o == 3'd1);
  p_byte_never_misaligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd0) |=> rsp_cause_o != 3'd1);
  p_cause_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_cause_o <= 3'd4);
  p_grant_iff_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_grant_o == (rsp_cause_o == 3'd0)));
endmodule

bind mem_perm_chk mem_perm_chk_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/sim_mem_perm_chk.sv
module sim_mem_perm_chk;
  localparam int CLK_PERIOD = 10;
  localparam int TBL_PAGES  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_page = '0;
  logic [2:0]  cfg_perm = '0;
  logic        rsp_valid, rsp_grant;
  logic [2:0]  rsp_cause;

  int errors = 0;
  int checks = 0;
  logic [2:0] model [TBL_PAGES];

  logic       pend = 1'b0;
  logic       e_valid, e_grant;
  logic [2:0] e_cause;
  string      e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_perm_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_kind_i(req_kind), .req_size_i(req_size), .cfg_we_i(cfg_we),
    .cfg_page_i(cfg_page), .cfg_perm_i(cfg_perm),
    .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant), .rsp_cause_o(rsp_cause)
  );

  function automatic logic [2:0] exp_cause(logic [23:0] a, logic [1:0] k, logic [1:0] s);
    logic mis;
    logic [2:0] p;
    int bitn;
    mis = (s == 2'd0) ? 1'b0 : (s == 2'd1) ? a[0] : (a[1:0] != 2'b00);
    p = (int'(a[23:8]) < TBL_PAGES) ? model[a[17:8]] : 3'b000;
    bitn = (k == 2'd0) ? 0 : (k == 2'd1) ? 1 : 2;
    if (mis) return 3'd1;
    if (!p[bitn]) return (k == 2'd0) ? 3'd2 : (k == 2'd1) ? 3'd3 : 3'd4;
    return 3'd0;
  endfunction

  task automatic check_pending();
    if (pend) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_grant !== e_grant || rsp_cause !== e_cause) begin
        errors++;
        $display("FAIL %s: valid/grant/cause got %0b/%0b/%0d expected %0b/%0b/%0d",
                 e_tag, rsp_valid, rsp_grant, rsp_cause, e_valid, e_grant, e_cause);
      end
    end
  endtask

  // One cycle: check previous response, then drive and predict the next
  task automatic cyc(input logic v, input logic [23:0] a, input logic [1:0] k,
                     input logic [1:0] s, input logic we, input logic [15:0] wp,
                     input logic [2:0] wv, input string tag);
    @(negedge clk);
    check_pending();
    req_valid = v; req_addr = a; req_kind = k; req_size = s;
    cfg_we = we; cfg_page = wp; cfg_perm = wv;
    e_valid = v;
    e_cause = v ? exp_cause(a, k, s) : 3'd0;
    e_grant = v && (e_cause == 3'd0);
    if (tag != "") e_tag = tag;
    else if (!v) e_tag = "R1";
    else if (e_cause == 3'd1) e_tag = "R4";
    else if (int'(a[23:8]) >= TBL_PAGES) e_tag = "R8";
    else e_tag = "R2";
    pend = 1'b1;
    if (we && int'(wp) < TBL_PAGES) model[wp[9:0]] = wv;  // R7: old entry seen this cycle
  endtask

  task automatic wr(input logic [15:0] p, input logic [2:0] v);
    cyc(1'b0, '0, '0, '0, 1'b1, p, v, "R1");
  endtask

  initial begin
    for (int i = 0; i < TBL_PAGES; i++) model[i] = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state of outputs
    checks++;
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_cause !== 3'd0) begin
      errors++;
      $display("FAIL R1: reset outputs got %0b/%0b/%0d expected 0/0/0", rsp_valid, rsp_grant, rsp_cause);
    end
    // R3: everything denied after reset
    cyc(1'b1, 24'h000100, 2'd0, 2'd2, 1'b0, '0, '0, "R3");
    cyc(1'b1, 24'h000200, 2'd1, 2'd2, 1'b0, '0, '0, "R3");
    cyc(1'b1, 24'h03FF00, 2'd2, 2'd2, 1'b0, '0, '0, "R3");
    // R6 / R9: grant after enabling each bit
    wr(16'd5, 3'b001);
    cyc(1'b1, 24'h000504, 2'd0, 2'd2, 1'b0, '0, '0, "R9");
    cyc(1'b1, 24'h000504, 2'd1, 2'd2, 1'b0, '0, '0, "R6");
    cyc(1'b1, 24'h000504, 2'd2, 2'd2, 1'b0, '0, '0, "R6");
    cyc(1'b1, 24'h000504, 2'd3, 2'd2, 1'b0, '0, '0, "R2");
    // R4: every size/offset combination on a fully permitted page
    wr(16'd6, 3'b111);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        cyc(1'b1, 24'h000600 | 24'(o), 2'(s), 2'(s), 1'b0, '0, '0, "R4");
    // R5: misaligned on a denied page still reports cause 1
    cyc(1'b1, 24'h000703, 2'd1, 2'd1, 1'b0, '0, '0, "R5");
    // R7: same-cycle write is not seen, next cycle is
    cyc(1'b1, 24'h000800, 2'd0, 2'd0, 1'b1, 16'd8, 3'b001, "R7");
    cyc(1'b1, 24'h000800, 2'd0, 2'd0, 1'b0, '0, '0, "R7");
    cyc(1'b1, 24'h000800, 2'd0, 2'd0, 1'b1, 16'd8, 3'b000, "R7");
    cyc(1'b1, 24'h000800, 2'd0, 2'd0, 1'b0, '0, '0, "R7");
    // R8: above the table, writes ignored and access denied; no alias onto low pages
    wr(16'd1024, 3'b111);
    wr(16'hFFFF, 3'b111);
    cyc(1'b1, 24'h040000, 2'd0, 2'd2, 1'b0, '0, '0, "R8");
    cyc(1'b1, 24'hFFFF00, 2'd2, 2'd2, 1'b0, '0, '0, "R8");
    cyc(1'b1, 24'h000000, 2'd0, 2'd2, 1'b0, '0, '0, "R8");
    wr(16'd1023, 3'b110);
    cyc(1'b1, 24'h03FFFC, 2'd1, 2'd2, 1'b0, '0, '0, "R8");
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] a;
      logic [15:0] wp;
      a  = ($urandom % 8 == 0) ? 24'($urandom) : {6'd0, 8'($urandom % 16), 2'b00, 8'($urandom)};
      wp = ($urandom % 10 == 0) ? 16'($urandom) : 16'($urandom % 16);
      cyc(($urandom % 5) != 0, a, 2'($urandom), 2'($urandom),
          ($urandom % 3) == 0, wp, 3'($urandom), "");
    end
    @(negedge clk);
    check_pending();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule